// File: doc/BRIEF.md
# Bit-Slip Aligned Serial-to-Parallel Converter

This block turns a serial bit stream into 8-bit parallel words. On every enabled clock it takes one NRZ bit from one of two serial lanes. A lane-select input picks the lane, so a second lane can carry a loop-back path for testing. The first bit of each word ends up in the least significant output bit. When the eighth bit of a word has been taken in, the whole word is loaded into a registered parallel output and a one-cycle valid strobe is raised.

Framing is adjusted with a slip request input. The request passes through a two-flop synchroniser. When it has been seen high on two enabled samples in a row, exactly one incoming bit is dropped, and every following word then starts one bit later in the stream. A held request gives only one slip. Another slip needs the request to go low and then return high. A clock-enable input freezes the whole block cleanly. An asynchronous active-high reset clears all state.

Top module: `bitslip_deser`

## Requirements
- R1: Within a word, the n-th accepted serial bit (counting from 0) appears on `word_out[n]`, so the first accepted bit of a word is `word_out[0]`.
- R2: With `lane_sel` = 0 the bit comes from `ser_a`, and with `lane_sel` = 1 it comes from `ser_b`. The selection is sampled on each enabled edge, and the other lane has no effect.
- R3: If `slip_req` is sampled high on two consecutive enabled edges k and k+1, the bit presented at enabled edge k+3 is discarded. The bit position within the word does not advance on that edge, so later words begin one bit later in the stream.
- R4: A request held high for any number of enabled cycles causes exactly one slip. Another slip needs `slip_req` to be sampled low at least once and then high again for two consecutive enabled samples.
- R5: `word_valid` is high for exactly the one cycle after the edge that accepted the eighth bit of a word. `word_out` changes only on that edge.
- R6: While `clk_en` is low at an edge, the block ignores its serial and slip inputs. The word position, partial word, output word and slip detector all hold, and `word_valid` is low after that edge.
- R7: While `rst` is high, `word_out` is 0 and `word_valid` is 0 at once, without waiting for a clock edge. After release, the first accepted bit starts a new word, and any earlier slip-request history is forgotten.
- R8: A `slip_req` that is high on only one enabled sample, with low samples on both sides, causes no slip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Asynchronous active-high master reset |
| clk_en | input | 1 | Clock enable; low freezes all state |
| lane_sel | input | 1 | Serial lane select (0 = ser_a, 1 = ser_b) |
| ser_a | input | 1 | Serial lane 0 |
| ser_b | input | 1 | Serial lane 1 (loop-back lane) |
| slip_req | input | 1 | Request to drop one bit and shift framing |
| word_out | output | 8 | Last completed parallel word, first bit in bit 0 |
| word_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
A wrong bit position or a lost slip shows up as a rotated or shifted `word_out` at the next strobe, at most eight enabled cycles later. A slip that comes too early, too late or too often also moves the time of the following strobes. The bench runs an independent model of the stream on every clock, so any difference in strobe timing or word content is reported in the cycle where it appears. A stuck slip detector is exposed by long-held and single-cycle requests, whose effect on framing is checked against fixed patterns.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int WORD_W_DEF      = 8;
    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic {
        DET_ARMED = 1'b0,
        DET_FIRED = 1'b1
    } det_state_t;

    typedef struct packed {
        logic take;   // accept the serial bit this edge
        logic slip;   // drop the serial bit this edge
        logic data;   // selected serial bit
    } bit_ctl_t;

    function automatic logic pick_lane(input logic sel, input logic a, input logic b);
        return sel ? b : a;
    endfunction

    function automatic bit_ctl_t make_ctl(input logic en, input logic slip, input logic data);
        bit_ctl_t c;
        c.slip = en & slip;
        c.take = en & ~slip;
        c.data = data;
        return c;
    endfunction

endpackage

// File: rtl/bsd_slip_detect.sv
module bsd_slip_detect
    import bsd_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic req_in,
    output logic slip_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    det_state_t        state_q;
    logic              synced;

    assign synced = sync_q[LAST];

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or posedge rst) begin
                if (rst)     sync_q <= '0;
                else if (en) sync_q <= req_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or posedge rst) begin
                if (rst)     sync_q <= '0;
                else if (en) sync_q <= {sync_q[STAGES-2:0], req_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or posedge rst) begin
        if (rst)     prev_q <= 1'b0;
        else if (en) prev_q <= synced;
    end

    assign slip_o = synced & prev_q & (state_q == DET_ARMED);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= DET_ARMED;
        end else if (en) begin
            if (!synced)     state_q <= DET_ARMED;
            else if (slip_o) state_q <= DET_FIRED;
        end
    end

    // R4: an executed slip is never followed by another on the next cycle
    p_single_slip_r4: assert property (@(posedge clk) disable iff (rst)
        (slip_o && en) |=> !slip_o)
        else $error("p_single_slip_r4");

    // R6: detector frozen while disabled
    p_det_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state_q) && $stable(sync_q))
        else $error("p_det_hold_r6");

endmodule

// File: rtl/bsd_shift_core.sv
module bsd_shift_core
    import bsd_pkg::*;
#(
    parameter int W = WORD_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  bit_ctl_t      ctl,
    output logic          done_o,
    output logic [W-1:0]  word_nxt_o
);
    localparam int             CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(W - 1);

    logic [W-1:0]     sh_q;
    logic [CNT_W-1:0] pos_q;

    // first accepted bit migrates down to bit 0 after W shifts
    assign word_nxt_o = {ctl.data, sh_q[W-1:1]};
    assign done_o     = ctl.take && (pos_q == LAST_POS);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sh_q  <= '0;
            pos_q <= '0;
        end else if (ctl.take) begin
            sh_q  <= word_nxt_o;
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + CNT_W'(1);
        end
    end

    // R3: a slip edge leaves position and partial word untouched
    p_slip_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ctl.slip |=> $stable(pos_q) && $stable(sh_q))
        else $error("p_slip_hold_r3");

    // R1: each accepted bit advances the position by one, wrapping after W
    p_pos_step_r1: assert property (@(posedge clk) disable iff (rst)
        ctl.take |=> pos_q == (($past(pos_q) == LAST_POS) ? '0 : $past(pos_q) + CNT_W'(1)))
        else $error("p_pos_step_r1");

endmodule

// File: rtl/bsd_out_reg.sv
module bsd_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_q,
    output logic         valid_q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) word_q <= word_in;
        end
    end

    // R5: output word moves only together with a strobe
    p_word_only_on_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(word_q) || $past(rst))
        else $error("p_word_only_on_strobe_r5");

endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
    import bsd_pkg::*;
#(
    parameter int WORD_W      = WORD_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              lane_sel,
    input  logic              ser_a,
    input  logic              ser_b,
    input  logic              slip_req,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    logic              slip;
    logic              done;
    logic [WORD_W-1:0] word_nxt;
    bit_ctl_t          ctl;

    bsd_slip_detect #(.STAGES(SYNC_STAGES)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .en     (clk_en),
        .req_in (slip_req),
        .slip_o (slip)
    );

    assign ctl = make_ctl(clk_en, slip, pick_lane(lane_sel, ser_a, ser_b));

    bsd_shift_core #(.W(WORD_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .done_o     (done),
        .word_nxt_o (word_nxt)
    );

    bsd_out_reg #(.W(WORD_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (done),
        .word_in (word_nxt),
        .word_q  (word_out),
        .valid_q (word_valid)
    );

    // R6: disabled edge yields no strobe and a frozen output
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> !word_valid && $stable(word_out))
        else $error("p_idle_hold_r6");

    // R5: strobe lasts a single cycle for words of more than one bit
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid || (WORD_W == 1))
        else $error("p_strobe_single_r5");

endmodule

// File: tb/bitslip_deser_bench.sv
module bitslip_deser_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic       lane_sel = 1'b0;
    logic       ser_a = 1'b0;
    logic       ser_b = 1'b0;
    logic       slip_req = 1'b0;
    logic [7:0] word_out;
    logic       word_valid;

    int checks = 0;
    int errors = 0;

    // reference model state
    int         m_pos;
    logic [7:0] m_acc;
    logic [7:0] m_word;
    logic       m_valid;
    logic       m_fired;
    logic       m_hist[$];   // enabled slip samples, newest first
    int         pat_i;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitslip_deser u_bitslip_deser (
        .clk(clk), .rst(rst), .clk_en(clk_en), .lane_sel(lane_sel),
        .ser_a(ser_a), .ser_b(ser_b), .slip_req(slip_req),
        .word_out(word_out), .word_valid(word_valid)
    );

    task automatic model_reset();
        m_pos = 0; m_acc = '0; m_word = '0; m_valid = 1'b0; m_fired = 1'b0;
        m_hist.delete();
        for (int i = 0; i < 3; i++) m_hist.push_back(1'b0);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(input logic en, input logic b, input logic req);
        logic do_slip;
        m_valid = 1'b0;
        if (en) begin
            do_slip = m_hist[1] && m_hist[2] && !m_fired;
            if (!m_hist[1]) m_fired = 1'b0;
            else if (do_slip) m_fired = 1'b1;
            m_hist.push_front(req);
            void'(m_hist.pop_back());
            if (!do_slip) begin
                m_acc[m_pos] = b;
                m_pos++;
                if (m_pos == 8) begin
                    m_word = m_acc; m_valid = 1'b1; m_pos = 0;
                end
            end
        end
    endtask

    // one clock: drive, edge, model, compare away from the edge
    task automatic step(input logic en, input logic sel, input logic b, input logic req, input string tag);
        clk_en = en; lane_sel = sel; slip_req = req;
        ser_a = sel ? ~b : b;
        ser_b = sel ? b : ~b;
        @(posedge clk);
        model_edge(en, b, req);
        @(negedge clk);
        check(tag, {31'd0, word_valid}, {31'd0, m_valid}, "word_valid");
        check(tag, {24'd0, word_out}, {24'd0, m_word}, "word_out");
    endtask

    task automatic send_byte(input logic [7:0] v, input logic sel, input string tag);
        for (int i = 0; i < 8; i++) step(1'b1, sel, v[i], 1'b0, tag);
    endtask

    task automatic pat_step(input logic req, input string tag);
        step(1'b1, 1'b0, (pat_i % 8) == 0, req, tag);
        pat_i++;
    endtask

    task automatic pat_run(input int n, input string tag);
        for (int i = 0; i < n; i++) pat_step(1'b0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        #1;
        check("R7", {24'd0, word_out}, 32'd0, "word_out in reset");
        check("R7", {31'd0, word_valid}, 32'd0, "word_valid in reset");
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        pat_i = 0;
        do_reset();

        // R1: LSB-first word assembly
        send_byte(8'hA5, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        check("R1", {24'd0, word_out}, 32'h0A5, "first word");
        for (int i = 1; i < 8; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R5");
        send_byte(8'h01, 1'b0, "R1");

        // R2: loop-back lane
        send_byte(8'h3C, 1'b1, "R2");
        check("R2", {24'd0, word_out}, 32'h03C, "lane b word");
        send_byte(8'hC3, 1'b0, "R2");

        // R6: disabled cycles mid-word with noisy inputs
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 6; i++) step(1'b0, i[0], i[1], 1'b1, "R6");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
        check("R6", {24'd0, word_out}, 32'h007, "word across disable");

        // framing pattern: one set bit per 8
        pat_i = 0;
        pat_run(16, "R3");
        check("R3", {24'd0, word_out}, 32'h001, "aligned pattern");
        // R3/R4: long hold, single slip
        for (int i = 0; i < 6; i++) pat_step(1'b1, "R4");
        pat_run(24, "R4");
        check("R3", {24'd0, word_out}, 32'h080, "after one slip");
        // R8: single-cycle request
        pat_step(1'b1, "R8");
        pat_run(24, "R8");
        check("R8", {24'd0, word_out}, 32'h080, "single sample no slip");
        // R4: two separate pulses give two slips
        for (int k = 0; k < 2; k++) begin
            pat_step(1'b1, "R4"); pat_step(1'b1, "R4");
            pat_run(4, "R4");
        end
        pat_run(24, "R4");
        check("R4", {24'd0, word_out}, 32'h020, "after two pulses");

        // R7: reset mid-word and with pending request history
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b1, "R7");
        do_reset();
        send_byte(8'h96, 1'b0, "R7");
        check("R7", {24'd0, word_out}, 32'h096, "word after reset");

        // mixed random traffic
        for (int i = 0; i < 400; i++)
            step(($urandom % 5) != 0, $urandom % 2, $urandom % 2, ($urandom % 4) == 0, "R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule